// File: doc/BRIEF.md
# Multi-Lane Serial Flash Read Sequencer

This block is the master side of a serial flash read. One start pulse begins a full read. The block lowers chip select and sends an 8-bit read opcode on lane 0. It then sends a 24-bit address and inserts a programmable number of idle clocks. After that it collects the requested number of bytes and presents each one with a single-cycle valid strobe. The read variant sets the lane width of the address and data phases. The options are one lane throughout, two or four lanes for data only, or two or four lanes for both address and data.

The serial clock runs at half the system clock in mode 0. It idles low. The block changes its outputs on falling edges and samples the inputs on rising edges. Each of the four data lanes has its own output and output enable, so the pad ring can build bidirectional pins from them.

Top module: `mio_flash_reader`

## Requirements
- R1: After reset and while idle, `cs_n` is 1, `sclk` is 0, `sio_oe` is 0000, `busy` is 0 and `rd_valid` is 0.
- R2: The opcode goes out MSB-first on `sio_o[0]`, one bit per rising edge. It depends on `variant`: 0 gives 0x0B (single), 1 gives 0x3B (dual data), 2 gives 0xBB (dual address and data), 3 gives 0x6B (quad data), 4 gives 0xEB (quad address and data). Codes 5 to 7 behave as 0.
- R3: The 24-bit address is sent MSB-first. Variants 0, 1 and 3 send it on `sio_o[0]`, one bit per clock. Variant 2 sends two bits per clock, with `sio_o[1]` carrying the higher bit. Variant 4 sends four bits per clock, with `sio_o[3]` carrying the highest bit.
- R4: Exactly `dummy_clks` rising edges (0 to 15) separate the address and the data. In the idle-clock and data phases `sio_oe` is 0000.
- R5: In variants 1 and 2, each byte takes 4 clocks. `sio_i[1]` supplies bits 7, 5, 3, 1 and `sio_i[0]` supplies bits 6, 4, 2, 0.
- R6: In variants 3 and 4, each byte takes 2 clocks, with `sio_i[3]` the highest bit of each nibble. In variant 0, each byte takes 8 clocks, MSB-first, on `sio_i[1]`.
- R7: `sclk` is low whenever `cs_n` is high. `sclk` stays high for exactly one system cycle. `sio_o` never changes at a rising edge.
- R8: `cs_n` stays low from the opcode through the last byte and then rises. The read returns `len_m1`+1 bytes (1 to 256), each with one `rd_valid` pulse while `cs_n` is low.
- R9: A start pulse while `busy` is ignored. The running read is unaffected and no new read follows it.
- R10: During the opcode and single-lane address clocks, `sio_oe` is 1101 and `sio_o[3:2]` is 11. During wide address clocks, `sio_oe` is 1111. In the dual address phase, `sio_o[3:2]` is 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a read (taken only when idle) |
| variant | input | 3 | Read variant code |
| addr | input | ADDR_W | Start address |
| dummy_clks | input | DUMMY_W | Idle clocks before data |
| len_m1 | input | LEN_W | Byte count minus one |
| busy | output | 1 | A read is in progress |
| sclk | output | 1 | Serial clock, mode 0 |
| cs_n | output | 1 | Chip select, active low |
| sio_o | output | 4 | Lane output values |
| sio_oe | output | 4 | Per-lane output enables |
| sio_i | input | 4 | Lane input values |
| rd_data | output | 8 | Assembled byte |
| rd_valid | output | 1 | One-cycle strobe for rd_data |

## Verification
The bench runs reads for every variant, with zero, one, seven and fifteen idle clocks, across several byte counts. It also runs one read of the maximum 256 bytes. A flash model in the bench drives returned bytes from an address-derived pattern.

A swapped lane order would garble each returned byte. Widening the bus in the wrong phase would break the captured address and the total clock count. An off-by-one in the idle-clock or byte counter would change the rising-edge total or the number of valid strobes. A design that re-armed on a start pulse during a read would lower `cs_n` again after finishing.

// File: rtl/mio_pkg.sv
package mio_pkg;

  localparam int OP_W = 8;

  localparam logic [2:0] VAR_SINGLE   = 3'd0;
  localparam logic [2:0] VAR_DUAL_DAT = 3'd1;
  localparam logic [2:0] VAR_DUAL_ALL = 3'd2;
  localparam logic [2:0] VAR_QUAD_DAT = 3'd3;
  localparam logic [2:0] VAR_QUAD_ALL = 3'd4;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_ADDR,
    PH_DUMMY,
    PH_DATA
  } phase_e;

  function automatic logic [OP_W-1:0] opcode_of(input logic [2:0] v);
    case (v)
      VAR_DUAL_DAT: return 8'h3B;
      VAR_DUAL_ALL: return 8'hBB;
      VAR_QUAD_DAT: return 8'h6B;
      VAR_QUAD_ALL: return 8'hEB;
      default:      return 8'h0B;
    endcase
  endfunction

  // log2 of the lane count used for the address phase
  function automatic logic [1:0] addr_lw(input logic [2:0] v);
    case (v)
      VAR_DUAL_ALL: return 2'd1;
      VAR_QUAD_ALL: return 2'd2;
      default:      return 2'd0;
    endcase
  endfunction

  // log2 of the lane count used for the data phase
  function automatic logic [1:0] data_lw(input logic [2:0] v);
    case (v)
      VAR_DUAL_DAT, VAR_DUAL_ALL: return 2'd1;
      VAR_QUAD_DAT, VAR_QUAD_ALL: return 2'd2;
      default:                    return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/mio_tx_lanes.sv
module mio_tx_lanes
  import mio_pkg::*;
(
  input  phase_e     phase,
  input  logic [1:0] alw,
  input  logic [3:0] head,
  output logic [3:0] sio_o,
  output logic [3:0] sio_oe
);

  always_comb begin
    sio_o  = 4'b0000;
    sio_oe = 4'b0000;
    case (phase)
      PH_CMD: begin
        sio_o  = {2'b11, 1'b0, head[3]};
        sio_oe = 4'b1101;
      end
      PH_ADDR: begin
        case (alw)
          2'd1: begin
            sio_o  = {2'b11, head[3], head[2]};
            sio_oe = 4'b1111;
          end
          2'd2: begin
            sio_o  = head;
            sio_oe = 4'b1111;
          end
          default: begin
            sio_o  = {2'b11, 1'b0, head[3]};
            sio_oe = 4'b1101;
          end
        endcase
      end
      default: begin
        sio_o  = 4'b0000;
        sio_oe = 4'b0000;
      end
    endcase
  end

endmodule

// File: rtl/mio_rx_assembler.sv
module mio_rx_assembler (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample,
  input  logic [1:0] dlw,
  input  logic [3:0] sio_i,
  output logic [7:0] shifted
);

  logic [7:0] acc_q;

  always_comb begin
    case (dlw)
      2'd1:    shifted = {acc_q[5:0], sio_i[1], sio_i[0]};
      2'd2:    shifted = {acc_q[3:0], sio_i[3:0]};
      default: shifted = {acc_q[6:0], sio_i[1]};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= 8'h00;
    else if (sample) acc_q <= shifted;
  end

endmodule

// File: rtl/mio_flash_reader.sv
module mio_flash_reader
  import mio_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int DUMMY_W = 4,
  parameter int LEN_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [2:0]         variant,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DUMMY_W-1:0] dummy_clks,
  input  logic [LEN_W-1:0]   len_m1,
  output logic               busy,
  output logic               sclk,
  output logic               cs_n,
  output logic [3:0]         sio_o,
  output logic [3:0]         sio_oe,
  input  logic [3:0]         sio_i,
  output logic [7:0]         rd_data,
  output logic               rd_valid
);

  localparam int SHIFT_W = OP_W + ADDR_W;
  localparam int MAXS    = (ADDR_W > (1 << DUMMY_W)) ? ADDR_W : (1 << DUMMY_W);
  localparam int CNT_W   = $clog2(MAXS + 1);

  phase_e               phase;
  logic                 sclk_q, cs_q;
  logic [SHIFT_W-1:0]   shreg;
  logic [CNT_W-1:0]     step_cnt, step_tgt;
  logic [LEN_W-1:0]     left_q;
  logic [2:0]           var_q;
  logic [DUMMY_W-1:0]   dummy_q;
  logic [1:0]           alw, dlw, lw_now;
  logic [7:0]           rx_next;

  // named events for the assertions
  logic rise_ev, fall_ev, step_last, byte_done;

  assign busy      = (phase != PH_IDLE);
  assign sclk      = sclk_q;
  assign cs_n      = cs_q;
  assign rise_ev   = busy && !sclk_q;
  assign fall_ev   = busy && sclk_q;
  assign byte_done = rise_ev && (phase == PH_DATA) && step_last;

  always_comb begin
    alw    = addr_lw(var_q);
    dlw    = data_lw(var_q);
    lw_now = (phase == PH_ADDR) ? alw : 2'd0;
    case (phase)
      PH_CMD:   step_tgt = CNT_W'(OP_W);
      PH_ADDR:  step_tgt = CNT_W'(ADDR_W) >> alw;
      PH_DUMMY: step_tgt = CNT_W'(dummy_q);
      PH_DATA:  step_tgt = CNT_W'(8) >> dlw;
      default:  step_tgt = CNT_W'(1);
    endcase
    step_last = (step_cnt == step_tgt - CNT_W'(1));
  end

  mio_tx_lanes i_tx (
    .phase  (phase),
    .alw    (alw),
    .head   (shreg[SHIFT_W-1 -: 4]),
    .sio_o  (sio_o),
    .sio_oe (sio_oe)
  );

  mio_rx_assembler i_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .sample  (rise_ev && (phase == PH_DATA)),
    .dlw     (dlw),
    .sio_i   (sio_i),
    .shifted (rx_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      sclk_q   <= 1'b0;
      cs_q     <= 1'b1;
      shreg    <= '0;
      step_cnt <= '0;
      left_q   <= '0;
      var_q    <= VAR_SINGLE;
      dummy_q  <= '0;
      rd_data  <= 8'h00;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (phase == PH_IDLE) begin
        if (start) begin
          phase    <= PH_CMD;
          cs_q     <= 1'b0;
          shreg    <= {opcode_of(variant), addr};
          step_cnt <= '0;
          left_q   <= len_m1;
          var_q    <= variant;
          dummy_q  <= dummy_clks;
        end
      end else if (rise_ev) begin
        sclk_q <= 1'b1;
        if (byte_done) begin
          rd_data  <= rx_next;
          rd_valid <= 1'b1;
        end
      end else begin
        sclk_q <= 1'b0;
        shreg  <= shreg << (3'd1 << lw_now);
        if (!step_last) begin
          step_cnt <= step_cnt + CNT_W'(1);
        end else begin
          step_cnt <= '0;
          case (phase)
            PH_CMD:   phase <= PH_ADDR;
            PH_ADDR:  phase <= (dummy_q != '0) ? PH_DUMMY : PH_DATA;
            PH_DUMMY: phase <= PH_DATA;
            PH_DATA: begin
              if (left_q == '0) begin
                phase <= PH_IDLE;
                cs_q  <= 1'b1;
              end else begin
                left_q <= left_q - LEN_W'(1);
              end
            end
            default:  phase <= PH_IDLE;
          endcase
        end
      end
    end
  end

  p_sclk_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  p_sclk_one_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |=> !sclk);

  p_tx_hold_at_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(sio_o));

  p_lanes_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DUMMY || phase == PH_DATA) |-> (sio_oe == 4'b0000));

  p_valid_in_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (!cs_n && sclk));

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(var_q) && $stable(dummy_q));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sio_oe == 4'b0000 && cs_n));

endmodule

// File: tb/test_mio_flash_reader.sv
module test_mio_flash_reader;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  variant = 3'd0;
  logic [23:0] addr = 24'h0;
  logic [3:0]  dummy_clks = 4'd0;
  logic [7:0]  len_m1 = 8'd0;
  logic        busy, sclk, cs_n, rd_valid;
  logic [3:0]  sio_o, sio_oe;
  logic [3:0]  sio_i = 4'b0000;
  logic [7:0]  rd_data;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mio_flash_reader i_mio_flash_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .variant(variant), .addr(addr),
    .dummy_clks(dummy_clks), .len_m1(len_m1), .busy(busy), .sclk(sclk),
    .cs_n(cs_n), .sio_o(sio_o), .sio_oe(sio_oe), .sio_i(sio_i),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // expectations of the running read
  int          e_an, e_dn, e_dm, e_n;
  logic [23:0] e_a;
  // monitor state
  int          rises, bytes_got, data_err, oe_err_hdr, oe_err_tail, clk_err, valid_err;
  logic [7:0]  cmd_cap;
  logic [23:0] addr_cap;
  bit          done;
  logic        prev_sclk = 1'b0, prev_cs = 1'b1;

  function automatic logic [7:0] exp_op(input int v);
    case (v)
      1: return 8'h3B;
      2: return 8'hBB;
      3: return 8'h6B;
      4: return 8'hEB;
      default: return 8'h0B;
    endcase
  endfunction

  function automatic int addr_lanes(input int v);
    return (v == 2) ? 2 : (v == 4) ? 4 : 1;
  endfunction

  function automatic int data_lanes(input int v);
    return (v == 1 || v == 2) ? 2 : (v == 3 || v == 4) ? 4 : 1;
  endfunction

  function automatic logic [7:0] pat(input logic [23:0] a, input int k);
    return 8'((a[7:0] ^ 8'hA5) + k * 29);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bus monitor and flash model, all at the falling system clock edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (cs_n && sclk) clk_err++;
      if (sclk && prev_sclk) clk_err++;
      if (!cs_n && prev_cs) begin
        rises = 0;
      end
      if (sclk && !prev_sclk && !cs_n) begin
        if (rises < 8) begin
          cmd_cap = {cmd_cap[6:0], sio_o[0]};
          if (sio_oe != 4'b1101 || sio_o[3:2] != 2'b11) oe_err_hdr++;
        end else if (rises < 8 + 24 / e_an) begin
          if (e_an == 1) begin
            addr_cap = {addr_cap[22:0], sio_o[0]};
            if (sio_oe != 4'b1101 || sio_o[3:2] != 2'b11) oe_err_hdr++;
          end else if (e_an == 2) begin
            addr_cap = {addr_cap[21:0], sio_o[1], sio_o[0]};
            if (sio_oe != 4'b1111 || sio_o[3:2] != 2'b11) oe_err_hdr++;
          end else begin
            addr_cap = {addr_cap[19:0], sio_o[3:0]};
            if (sio_oe != 4'b1111) oe_err_hdr++;
          end
        end else begin
          if (sio_oe != 4'b0000) oe_err_tail++;
        end
        rises++;
      end
      if (!sclk && prev_sclk && !cs_n) begin
        int j, spb, b, w, bits;
        j = rises - (8 + 24 / e_an + e_dm);
        if (j >= 0) begin
          spb  = 8 / e_dn;
          b    = int'(pat(e_a, j / spb));
          w    = j % spb;
          bits = b >> (8 - e_dn * (w + 1));
          if (e_dn == 1)      sio_i = {2'b00, bits[0], 1'b0};
          else if (e_dn == 2) sio_i = {2'b00, bits[1:0]};
          else                sio_i = bits[3:0];
        end
      end
      if (rd_valid) begin
        if (cs_n) valid_err++;
        if (rd_data != pat(e_a, bytes_got)) data_err++;
        bytes_got++;
      end
      if (cs_n && !prev_cs) done = 1'b1;
      prev_sclk = sclk;
      prev_cs   = cs_n;
    end
  end

  task automatic run(input int v, input logic [23:0] a, input int dm,
                     input int n, input bit poke);
    int    exp_rises;
    string dreq;
    @(negedge clk);
    while (busy) @(negedge clk);
    e_an = addr_lanes(v); e_dn = data_lanes(v); e_dm = dm; e_n = n; e_a = a;
    bytes_got = 0; data_err = 0; oe_err_hdr = 0; oe_err_tail = 0;
    clk_err = 0; valid_err = 0; cmd_cap = 8'h00; addr_cap = 24'h0; done = 1'b0;
    variant = 3'(v); addr = a; dummy_clks = 4'(dm); len_m1 = 8'(n - 1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (20) @(negedge clk);
      variant = 3'd4; addr = ~a; dummy_clks = 4'd3; len_m1 = 8'd0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    exp_rises = 8 + 24 / e_an + dm + n * 8 / e_dn;
    dreq = (e_dn == 2) ? "R5" : "R6";
    chk(cmd_cap == exp_op(v), "R2", "opcode", cmd_cap, exp_op(v));
    chk(addr_cap == a, "R3", "address", addr_cap, a);
    chk(oe_err_hdr == 0, "R10", "header lane enables", oe_err_hdr, 0);
    chk(oe_err_tail == 0, "R4", "lanes released after address", oe_err_tail, 0);
    chk(rises == exp_rises, "R4", "rising edge total", rises, exp_rises);
    chk(bytes_got == n, "R8", "byte strobes", bytes_got, n);
    chk(valid_err == 0, "R8", "strobe outside frame", valid_err, 0);
    chk(data_err == 0, dreq, "returned bytes", data_err, 0);
    chk(clk_err == 0, "R7", "clock shape", clk_err, 0);
    if (poke) begin
      int lows = 0;
      repeat (8) begin
        @(negedge clk);
        if (!cs_n || busy) lows++;
      end
      chk(lows == 0, "R9", "no read after ignored start", lows, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b0, "R1", "reset cs/sclk", {cs_n, sclk}, 2'b10);
    chk(sio_oe == 4'b0000, "R1", "reset lane enables", sio_oe, 0);
    chk(busy == 1'b0 && rd_valid == 1'b0, "R1", "reset busy/valid", {busy, rd_valid}, 0);
    rst_n = 1'b1;
    for (int v = 0; v < 5; v++) begin
      for (int di = 0; di < 4; di++) begin
        for (int ni = 0; ni < 2; ni++) begin
          int dm;
          dm = (di == 0) ? 0 : (di == 1) ? 1 : (di == 2) ? 7 : 15;
          run(v, 24'h5A3C0F ^ 24'(v * 24'h111111) ^ 24'(di * 24'h030507),
              dm, (ni == 0) ? 1 : 3, 1'b0);
        end
      end
    end
    run(4, 24'hFEDCBA, 6, 256, 1'b0);
    run(0, 24'h800001, 0, 5, 1'b0);
    run(7, 24'h123456, 2, 2, 1'b0);
    run(2, 24'hC0FFEE, 4, 4, 1'b1);
    run(3, 24'h00000F, 0, 2, 1'b1);
    @(negedge clk);
    chk(cs_n == 1'b1 && sio_oe == 4'b0000, "R1", "idle after reads",
        {cs_n, sio_oe}, 5'b10000);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule